// File: doc/BRIEF.md
# Audio Limiter Gain Engine with Battery-Dip Priority

This block decides how much attenuation an audio playback path applies. Two requests can ask for it. A limiter request is raised when the peak level of the output is above the limiter threshold. A battery-dip request is raised when the battery sample falls below its brown-out threshold. The battery-dip request always takes priority, and it works even when the limiter is switched off. Each request raises the attenuation in steps at its own rate and step size. When no request is active, the block holds the attenuation for a programmed time and then lowers it step by step back to 0 dB. Both requests share one attenuation ceiling.

The level comparison and the gain multiplier are outside this block. The block reports attenuation as a count of 0.25 dB units. It also drives a latched shutdown request for the battery-dip case and shows its current state. A one-cycle clear strobe ends an optional infinite hold after a battery dip. Mute or shutdown returns the engine to zero attenuation.

The state encoding is IDLE=0, LIM_ATK=1, BOP_ATK=2, HOLD=3 and RELEASE=4. The transitions are:
- IDLE/HOLD/RELEASE→LIM_ATK when a limiter request appears.
- any→BOP_ATK when a battery-dip request appears.
- LIM_ATK or BOP_ATK→HOLD when its request ends.
- HOLD→RELEASE when the hold time runs out or the clear strobe arrives.
- RELEASE→IDLE when attenuation reaches 0.
- any→IDLE on mute or shutdown.

Timing:
- A prescaler divides the clock by `TICK_DIV` to make a 1 µs tick.
- One millisecond is `US_PER_MS` ticks.
- An attack step lands on the edge that enters an attack state, and then once every attack period.

Top module: `lim_gain_engine`

## Requirements
- R1: After reset, `atten_q` is 0, `state_o` is IDLE (0) and `sd_req` is 0.
- R2: While `bop_en` and `vbat_low` are both high, the state becomes BOP_ATK (2) on the next edge.
  - One step is added on that edge, then one more every attack period of 5<<`bop_atk_rate` µs.
  - The step is 2·(`bop_atk_step`+1) quarter-dB units.
- R3: While `lim_en` and `peak_over` are both high and there is no battery-dip request, the state becomes LIM_ATK (1).
  - Steps follow the same timing as R2.
  - The step is 1<<`lim_atk_step` quarter-dB units, and the period is 5<<`lim_atk_rate` µs.
- R4: With `lim_en` low, `peak_over` has no effect on `atten_q` or `state_o`.
- R5: A battery-dip request wins over a limiter request, and it operates whether `lim_en` is high or low.
- R6: An attack step never raises `atten_q` above the ceiling 4+2·`max_atten` quarter-dB units. Both requests share this ceiling.
- R7: When the attack request ends, the state becomes HOLD (3). It stays in HOLD for the hold time (0,10,25,50,100,250,500,1000 ms selected by a 3-bit code), and then becomes RELEASE (4).
  - The hold code is `bop_hold` after BOP_ATK.
  - The hold code is `lim_hold` after LIM_ATK.
- R8: In RELEASE, attenuation falls by 1<<`lim_rel_step` units, clamped at 0, once every release period. The release period is 10,50,100,250,500,750,1000,1500 ms selected by `lim_rel_rate`. At 0 the state becomes IDLE.
- R9: A new attack request during HOLD or RELEASE returns the engine to attack on the next edge, with an immediate step.
- R10: If `inf_hold` was high when leaving BOP_ATK, HOLD lasts until a `hold_clr` strobe. The state then becomes RELEASE on the next edge.
- R11: On the edge after `mute` or `shutdown` is high, `atten_q` is 0 and the state is IDLE. Any infinite hold is also cleared.
- R12: With `bop_sd_en` high, a battery-dip request sets `sd_req` on the next edge. `sd_req` stays set through mute and stays until an edge where `shutdown` is high, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| peak_over | input | 1 | Output peak above limiter threshold |
| vbat_low | input | 1 | Battery sample below brown-out threshold |
| mute | input | 1 | Mute state |
| shutdown | input | 1 | Shutdown state |
| lim_en | input | 1 | Limiter enable |
| bop_en | input | 1 | Battery-dip path enable |
| lim_atk_rate | input | 3 | Limiter attack period code |
| lim_atk_step | input | 2 | Limiter attack step code |
| lim_hold | input | 3 | Limiter hold code |
| lim_rel_rate | input | 3 | Release period code |
| lim_rel_step | input | 2 | Release step code |
| bop_atk_rate | input | 3 | Battery-dip attack period code |
| bop_atk_step | input | 2 | Battery-dip attack step code |
| bop_hold | input | 3 | Battery-dip hold code |
| max_atten | input | 5 | Attenuation ceiling code |
| inf_hold | input | 1 | Hold forever after a battery dip |
| hold_clr | input | 1 | One-cycle strobe ending an infinite hold |
| bop_sd_en | input | 1 | Latch shutdown request on battery dip |
| atten_q | output | 7 | Attenuation, 0.25 dB units |
| sd_req | output | 1 | Latched shutdown request |
| state_o | output | 3 | Engine state |

## Verification
The hardest situations to reach are the ones that depend on history. One is the shared ceiling after the limiter has already used part of the budget. Another is an infinite hold that ignores its timer and waits only for the clear strobe. Each run starts from a mute pulse. A limiter attack first builds partial attenuation, and a battery dip is then stacked on top of it. For the hold case, the bench waits far beyond any programmed hold time before it issues the strobe. The random trials pick the step, period and ceiling codes and a random number of edges. The bench then compares the accumulated attenuation with a closed-form count of steps.

// File: rtl/lim_gain_pkg.sv
package lim_gain_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LIM_ATK = 3'd1,
        ST_BOP_ATK = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RELEASE = 3'd4
    } lge_state_e;

    // attack period in microseconds
    function automatic int unsigned atk_us(input logic [2:0] code);
        return 32'd5 << code;
    endfunction

    function automatic int unsigned hold_ms(input logic [2:0] code);
        case (code)
            3'd0: return 0;
            3'd1: return 10;
            3'd2: return 25;
            3'd3: return 50;
            3'd4: return 100;
            3'd5: return 250;
            3'd6: return 500;
            default: return 1000;
        endcase
    endfunction

    function automatic int unsigned rel_ms(input logic [2:0] code);
        case (code)
            3'd0: return 10;
            3'd1: return 50;
            3'd2: return 100;
            3'd3: return 250;
            3'd4: return 500;
            3'd5: return 750;
            3'd6: return 1000;
            default: return 1500;
        endcase
    endfunction

    function automatic int unsigned lim_step_q(input logic [1:0] code);
        return 32'd1 << code;
    endfunction

    function automatic int unsigned bop_step_q(input logic [1:0] code);
        return 2 * (32'(code) + 1);
    endfunction

    function automatic int unsigned cap_q(input logic [4:0] code);
        return 4 + 2 * 32'(code);
    endfunction

endpackage

// File: rtl/lge_tick_gen.sv
module lge_tick_gen #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      cnt <= '0;
                else if (cnt == CW'(DIV - 1))    cnt <= '0;
                else                             cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/lge_interval_timer.sv
module lge_interval_timer #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] period,
    output logic         done
);
    logic [W-1:0] cnt;
    logic [W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign done    = tick && (cnt_inc >= {1'b0, period});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt_inc[W-1:0];
    end
endmodule

// File: rtl/lge_atten_step.sv
module lge_atten_step #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] cur,
    input  logic [3:0]    amt,
    input  logic          up,
    input  logic [AW-1:0] cap,
    output logic [AW-1:0] nxt
);
    logic [AW:0] sum;

    always_comb begin
        sum = {1'b0, cur} + (AW+1)'(amt);
        if (up) begin
            if (cur >= cap)                nxt = cur;
            else if (sum > {1'b0, cap})    nxt = cap;
            else                           nxt = sum[AW-1:0];
        end else begin
            if (cur > AW'(amt))            nxt = cur - AW'(amt);
            else                           nxt = '0;
        end
    end
endmodule

// File: rtl/lim_gain_engine.sv
module lim_gain_engine
    import lim_gain_pkg::*;
#(
    parameter int TICK_DIV  = 100,
    parameter int US_PER_MS = 1000,
    parameter int AW        = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          peak_over,
    input  logic          vbat_low,
    input  logic          mute,
    input  logic          shutdown,
    input  logic          lim_en,
    input  logic          bop_en,
    input  logic [2:0]    lim_atk_rate,
    input  logic [1:0]    lim_atk_step,
    input  logic [2:0]    lim_hold,
    input  logic [2:0]    lim_rel_rate,
    input  logic [1:0]    lim_rel_step,
    input  logic [2:0]    bop_atk_rate,
    input  logic [1:0]    bop_atk_step,
    input  logic [2:0]    bop_hold,
    input  logic [4:0]    max_atten,
    input  logic          inf_hold,
    input  logic          hold_clr,
    input  logic          bop_sd_en,
    output logic [AW-1:0] atten_q,
    output logic          sd_req,
    output logic [2:0]    state_o
);
    localparam int TW = $clog2(1500 * US_PER_MS + 1);

    lge_state_e    state_q, state_n;
    logic          hold_bop_q, hold_bop_n;
    logic          inf_q, inf_n;
    logic          tick, done, clr;
    logic          step_en, step_up;
    logic [3:0]    step_amt;
    logic [AW-1:0] step_nxt, cap;
    logic [TW-1:0] period;
    logic          bop_act, lim_act, quiet;

    assign bop_act = bop_en & vbat_low;
    assign lim_act = lim_en & peak_over;
    assign quiet   = mute | shutdown;
    assign cap     = AW'(cap_q(max_atten));

    lge_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    lge_interval_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr),
        .period(period), .done(done)
    );

    lge_atten_step #(.AW(AW)) u_step (
        .cur(atten_q), .amt(step_amt), .up(step_up), .cap(cap), .nxt(step_nxt)
    );

    // timer period for the current state
    always_comb begin
        unique case (state_q)
            ST_LIM_ATK: period = TW'(atk_us(lim_atk_rate));
            ST_BOP_ATK: period = TW'(atk_us(bop_atk_rate));
            ST_HOLD:    period = hold_bop_q ? TW'(hold_ms(bop_hold) * US_PER_MS)
                                            : TW'(hold_ms(lim_hold) * US_PER_MS);
            ST_RELEASE: period = TW'(rel_ms(lim_rel_rate) * US_PER_MS);
            default:    period = '0;
        endcase
    end

    // next state and step decision
    always_comb begin
        state_n    = state_q;
        hold_bop_n = hold_bop_q;
        inf_n      = inf_q;
        step_en    = 1'b0;
        step_up    = 1'b1;
        step_amt   = '0;
        if (quiet) begin
            state_n = ST_IDLE;
            inf_n   = 1'b0;
        end else if (bop_act) begin
            state_n  = ST_BOP_ATK;
            step_amt = 4'(bop_step_q(bop_atk_step));
            step_en  = (state_q != ST_BOP_ATK) || done;
        end else if (lim_act) begin
            state_n  = ST_LIM_ATK;
            step_amt = 4'(lim_step_q(lim_atk_step));
            step_en  = (state_q != ST_LIM_ATK) || done;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_LIM_ATK: begin
                    state_n    = ST_HOLD;
                    hold_bop_n = 1'b0;
                    inf_n      = 1'b0;
                end
                ST_BOP_ATK: begin
                    state_n    = ST_HOLD;
                    hold_bop_n = 1'b1;
                    inf_n      = inf_hold;
                end
                ST_HOLD: begin
                    if (inf_q ? hold_clr : done) begin
                        state_n = ST_RELEASE;
                        inf_n   = 1'b0;
                    end
                end
                ST_RELEASE: begin
                    step_up  = 1'b0;
                    step_amt = 4'(lim_step_q(lim_rel_step));
                    if (done) begin
                        step_en = 1'b1;
                        if (step_nxt == '0) state_n = ST_IDLE;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    assign clr = (state_n != state_q) | step_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            hold_bop_q <= 1'b0;
            inf_q      <= 1'b0;
        end else begin
            state_q    <= state_n;
            hold_bop_q <= hold_bop_n;
            inf_q      <= inf_n;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            atten_q <= '0;
            sd_req  <= 1'b0;
        end else begin
            if (quiet)        atten_q <= '0;
            else if (step_en) atten_q <= step_nxt;
            if (shutdown)                  sd_req <= 1'b0;
            else if (bop_act && bop_sd_en) sd_req <= 1'b1;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/lim_gain_engine_chk.sv
module lim_gain_engine_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vbat_low,
    input logic          mute,
    input logic          shutdown,
    input logic          bop_en,
    input logic [4:0]    max_atten,
    input logic          bop_sd_en,
    input logic [AW-1:0] atten_q,
    input logic          sd_req,
    input logic [2:0]    state_o
);
    // R11
    quiet_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute || shutdown) |=> (atten_q == '0 && state_o == 3'd0));

    // R12
    sd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> !sd_req);

    // R12
    sd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_req) |-> $past(bop_en && vbat_low && bop_sd_en));

    // R5
    bop_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bop_en && vbat_low && !mute && !shutdown) |=> state_o == 3'd2);

    // R6
    cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (atten_q > $past(atten_q)) |-> (32'(atten_q) <= 4 + 2 * 32'($past(max_atten))));

    // R8
    release_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) == 3'd4) |-> atten_q <= $past(atten_q));
endmodule

bind lim_gain_engine lim_gain_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/lim_gain_engine_tb.sv
module lim_gain_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int US_MS      = 2;

    logic clk = 0, rst_n = 0;
    logic peak_over = 0, vbat_low = 0, mute = 0, shutdown = 0;
    logic lim_en = 0, bop_en = 1;
    logic [2:0] lim_atk_rate = 2, lim_hold = 6, lim_rel_rate = 6, bop_atk_rate = 2, bop_hold = 6;
    logic [1:0] lim_atk_step = 1, lim_rel_step = 1, bop_atk_step = 1;
    logic [4:0] max_atten = 16;
    logic inf_hold = 0, hold_clr = 0, bop_sd_en = 0;
    logic [6:0] atten_q;
    logic sd_req;
    logic [2:0] state_o;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lim_gain_engine #(.TICK_DIV(1), .US_PER_MS(US_MS), .AW(7)) u_dut (.*);

    function automatic int exp_atk(int step, int per, int cap, int m);
        int v = step * (1 + (m - 1) / per);
        return (v > cap) ? cap : v;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet_pulse();
        mute = 1; edges(1); mute = 0;
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(1234));
        edges(3);
        rst_n = 1;
        edges(1);
        // R1
        chk("R1 atten", atten_q, 0);
        chk("R1 state", state_o, 0);
        chk("R1 sd_req", sd_req, 0);

        // R4: limiter disabled
        peak_over = 1; edges(20);
        chk("R4 atten", atten_q, 0);
        chk("R4 state", state_o, 0);
        peak_over = 0;

        // R2 random battery-dip attacks (limiter off: R5)
        for (int t = 0; t < 30; t++) begin
            int m;
            bop_atk_rate = 3'($urandom_range(0, 2));
            bop_atk_step = 2'($urandom_range(0, 3));
            max_atten    = 5'($urandom_range(0, 31));
            m = $urandom_range(1, 60);
            quiet_pulse();
            vbat_low = 1; edges(m);
            chk("R2 atten", atten_q, exp_atk(2*(bop_atk_step+1), 5 << bop_atk_rate, 4+2*max_atten, m));
            chk("R2 state", state_o, 2);
            vbat_low = 0; mute = 1; edges(1); mute = 0;
        end

        // R3 random limiter attacks
        lim_en = 1;
        for (int t = 0; t < 30; t++) begin
            int m;
            lim_atk_rate = 3'($urandom_range(0, 2));
            lim_atk_step = 2'($urandom_range(0, 3));
            max_atten    = 5'($urandom_range(0, 31));
            m = $urandom_range(1, 60);
            quiet_pulse();
            peak_over = 1; edges(m);
            chk("R3 atten", atten_q, exp_atk(1 << lim_atk_step, 5 << lim_atk_rate, 4+2*max_atten, m));
            chk("R3 state", state_o, 1);
            peak_over = 0; mute = 1; edges(1); mute = 0;
        end

        // R6 shared ceiling, R5 priority
        max_atten = 2; lim_atk_rate = 0; lim_atk_step = 1;
        bop_atk_rate = 0; bop_atk_step = 1;
        quiet_pulse();
        peak_over = 1; edges(6);
        chk("R6 limiter part", atten_q, 4);
        vbat_low = 1; edges(1);
        chk("R5 priority state", state_o, 2);
        chk("R6 shared cap", atten_q, 8);
        edges(12);
        chk("R6 held at cap", atten_q, 8);
        peak_over = 0; vbat_low = 0; quiet_pulse();

        // R7/R8 hold then release
        max_atten = 16; bop_hold = 1; lim_rel_rate = 0; lim_rel_step = 1;
        vbat_low = 1; edges(11);
        chk("R2 three steps", atten_q, 12);
        vbat_low = 0; edges(20);
        chk("R7 still hold", state_o, 3);
        edges(1);
        chk("R7 to release", state_o, 4);
        chk("R8 release start", atten_q, 12);
        edges(19);
        chk("R8 before step", atten_q, 12);
        edges(1);
        chk("R8 first step", atten_q, 10);
        // R9 re-attack from release
        peak_over = 1; edges(1);
        chk("R9 state", state_o, 1);
        chk("R9 atten", atten_q, 12);
        peak_over = 0; edges(1);
        chk("R7 limiter hold", state_o, 3);
        quiet_pulse();

        // R8 full release to idle
        vbat_low = 1; edges(11); vbat_low = 0;
        edges(140);
        chk("R8 near end", atten_q, 2);
        edges(1);
        chk("R8 idle state", state_o, 0);
        chk("R8 idle atten", atten_q, 0);

        // R10 infinite hold
        inf_hold = 1;
        vbat_low = 1; edges(11); vbat_low = 0;
        edges(200);
        chk("R10 hold forever", state_o, 3);
        chk("R10 atten kept", atten_q, 12);
        hold_clr = 1; edges(1); hold_clr = 0;
        chk("R10 released", state_o, 4);
        edges(20);
        chk("R10 release step", atten_q, 10);
        // R11 mute ends infinite hold
        quiet_pulse();
        vbat_low = 1; edges(3); vbat_low = 0; edges(50);
        chk("R10 second hold", state_o, 3);
        mute = 1; edges(1);
        chk("R11 mute atten", atten_q, 0);
        chk("R11 mute state", state_o, 0);
        mute = 0; edges(5);
        chk("R11 stays idle", state_o, 0);
        inf_hold = 0;

        // R12 shutdown request latch
        bop_sd_en = 1; vbat_low = 1; edges(1);
        chk("R12 set", sd_req, 1);
        vbat_low = 0; quiet_pulse(); edges(3);
        chk("R12 kept over mute", sd_req, 1);
        shutdown = 1; edges(1);
        chk("R12 cleared", sd_req, 0);
        chk("R11 shutdown state", state_o, 0);
        shutdown = 0; edges(3);
        chk("R12 stays clear", sd_req, 0);

        finish_up();
    end
endmodule